// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Responder

This block sits as a slave on a 32-bit processor bus, on the interrupt side. Seven request lines, one per priority level, come in from peripherals. The block encodes the highest active level onto a 3-bit level output for the processor. Levels 1 to 6 are level-sensitive and follow their lines. Level 7 is the non-maskable level. It is captured on a rising edge and held until the processor acknowledges it.

When the processor takes an interrupt, it runs a special read cycle. The transfer type marks the cycle as CPU space, and the address and transfer modifier both carry the level being served. The block checks this cycle in full. It then returns the 8-bit vector that software loaded for that level on the top byte lane of the data bus, and ends the cycle with a one-clock transfer acknowledge. The data lane is enabled only during that acknowledge.

Top module: `irq_vec_responder`

## Requirements
- R1: After reset the level output is 0, and transfer acknowledge and data-lane enable are low.
- R2: The level output equals the highest level in 1..7 that is active, or 0 when none is active. Each level line is sampled at a clock edge and is reflected on the output after that edge.
- R3: A cycle is answered only when the transfer type equals 2'b11.
- R4: A cycle is answered only when address bits [31:5] are all ones and address bits [1:0] are 2'b00.
- R5: A cycle is answered only when address bits [4:2] equal the 3-bit transfer modifier, that value is nonzero, and that level is currently active.
- R6: A matching address phase in cycle N produces the acknowledge for exactly one clock in cycle N+1. In that same cycle the data lane carries the vector of the acknowledged level, and the data-lane enable is high.
- R7: Outside an acknowledge cycle, the acknowledge and data-lane enable stay low and the data lane reads 0.
- R8: A level-7 request is cleared by the clock edge that ends its acknowledge, so the level output leaves 7 after that edge.
- R9: Once a rising edge on the level-7 line is captured, the level output stays at 7 until a level-7 acknowledge is given, even if the line falls.
- R10: A level-7 line held high across its acknowledge does not request again. A new rising edge is needed. An edge captured at the same edge that clears the request takes precedence, so the request stays.
- R11: A vector write with a level select in 1..7 loads that level's 8-bit vector. A write with select 0 changes no vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 7 | Request lines, bit i-1 is level i |
| vec_we | input | 1 | Vector write strobe |
| vec_sel | input | 3 | Level whose vector is written |
| vec_wdata | input | 8 | Vector write value |
| bus_valid | input | 1 | Address phase valid |
| bus_addr | input | 32 | Bus address |
| bus_tt | input | 2 | Transfer type |
| bus_tm | input | 3 | Transfer modifier |
| ipl | output | 3 | Encoded request level to the processor |
| d_hi | output | 8 | Vector on data bits 31:24 |
| d_oe | output | 1 | Enable for data bits 31:24 |
| ta | output | 1 | Transfer acknowledge |

## Verification
The level-7 request can be cleared by its own acknowledge at the same clock edge that captures a new rising edge on the level-7 line. The bench provokes this by raising the line exactly in the acknowledge clock of a level-7 cycle. It judges the result by the level output after that edge, which must still read 7. A later second acknowledge must then drop it to 0.

// File: rtl/irq_vec_responder.sv
`timescale 1ns/1ps
module irq_vec_responder #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:1]       irq_req,
  input  logic             vec_we,
  input  logic [2:0]       vec_sel,
  input  logic [VEC_W-1:0] vec_wdata,
  input  logic             bus_valid,
  input  logic [31:0]      bus_addr,
  input  logic [1:0]       bus_tt,
  input  logic [2:0]       bus_tm,
  output logic [2:0]       ipl,
  output logic [VEC_W-1:0] d_hi,
  output logic             d_oe,
  output logic             ta
);
  logic [7:1]       act;
  logic             req7_q;
  logic             ack_q;
  logic [2:0]       ack_lvl;
  logic [VEC_W-1:0] vec [0:7];

  wire [7:0] act_full = {act, 1'b0};
  wire match = bus_valid & ~ack_q & (bus_tt == 2'b11) & (&bus_addr[31:5])
             & (bus_addr[1:0] == 2'b00) & (bus_addr[4:2] == bus_tm) & act_full[bus_tm];
  wire set7 = irq_req[7] & ~req7_q;
  wire clr7 = ack_q & (ack_lvl == 3'd7);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act     <= '0;
      req7_q  <= 1'b0;
      ack_q   <= 1'b0;
      ack_lvl <= '0;
      for (int i = 0; i < 8; i++) vec[i] <= '0;
    end else begin
      act[6:1] <= irq_req[6:1];
      act[7]   <= set7 | (act[7] & ~clr7);
      req7_q   <= irq_req[7];
      ack_q    <= match;
      if (match) ack_lvl <= bus_tm;
      if (vec_we && vec_sel != 3'd0) vec[vec_sel] <= vec_wdata;
    end
  end

  always_comb begin
    ipl = '0;
    for (int i = 1; i < 8; i++)
      if (act[i]) ipl = 3'(i);
  end

  assign ta   = ack_q;
  assign d_oe = ack_q;
  assign d_hi = ack_q ? vec[ack_lvl] : '0;
endmodule

module irq_vec_responder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic [31:0] bus_addr,
  input logic [1:0]  bus_tt,
  input logic [2:0]  ipl,
  input logic        ta
);
  // R6
  ta_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ta |=> !ta);
  // R6
  ta_after_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ta |-> $past(bus_valid && bus_tt == 2'b11));
  // R3
  tt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_tt != 2'b11) |=> !ta);
  // R4
  low_addr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_addr[1:0] != 2'b00) |=> !ta);
  // R9
  nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ipl == 3'd7 && !ta) |=> ipl == 3'd7);
endmodule

bind irq_vec_responder irq_vec_responder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
  .bus_tt(bus_tt), .ipl(ipl), .ta(ta)
);

// File: tb/irq_vec_responder_tb_top.sv
`timescale 1ns/1ps
module irq_vec_responder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:1] irq_req = '0;
  logic vec_we = 1'b0;
  logic [2:0] vec_sel = '0;
  logic [7:0] vec_wdata = '0;
  logic bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [1:0] bus_tt = '0;
  logic [2:0] bus_tm = '0;
  logic [2:0] ipl;
  logic [7:0] d_hi;
  logic d_oe, ta;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_vec_responder dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .vec_we(vec_we),
    .vec_sel(vec_sel), .vec_wdata(vec_wdata), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_tt(bus_tt), .bus_tm(bus_tm),
    .ipl(ipl), .d_hi(d_hi), .d_oe(d_oe), .ta(ta)
  );

  function automatic logic [7:0] vexp(input int l);
    return 8'(8'h30 + l * 17);
  endfunction

  function automatic logic [31:0] ack_addr(input logic [2:0] l);
    return {27'h7FF_FFFF, l, 2'b00};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_cycle(input logic [31:0] a, input logic [1:0] tt, input logic [2:0] tm,
                           input bit hit, input logic [7:0] v, input string tag);
    bus_valid = 1'b1; bus_addr = a; bus_tt = tt; bus_tm = tm;
    tick();
    bus_valid = 1'b0;
    check({tag, " ta"}, ta, hit);
    check({tag, " oe"}, d_oe, hit);
    check({tag, " data"}, d_hi, hit ? v : 8'h00);
    tick();
    check({tag, " ta one clock"}, ta, 0);
  endtask

  initial begin
    tick(); tick();
    // R1
    check("R1 ipl", ipl, 0);
    check("R1 ta", ta, 0);
    check("R1 oe", d_oe, 0);
    rst_n = 1'b1;
    tick();
    // R11 program vectors, then a select-0 write
    for (int l = 1; l < 8; l++) begin
      vec_we = 1'b1; vec_sel = 3'(l); vec_wdata = vexp(l); tick();
    end
    vec_sel = 3'd0; vec_wdata = 8'hFF; tick();
    vec_we = 1'b0;
    // R2 sweep all level 1..6 masks
    for (int m = 0; m < 64; m++) begin
      int hi;
      irq_req[6:1] = 6'(m);
      tick();
      hi = 0;
      for (int b = 0; b < 6; b++) if (m[b]) hi = b + 1;
      check("R2 ipl", ipl, hi);
    end
    // R5 R6 R7 R11 sweep masks and modifiers
    for (int m = 0; m < 64; m += 5) begin
      irq_req[6:1] = 6'(m);
      tick();
      for (int t = 0; t < 8; t++) begin
        bit h;
        h = (t >= 1 && t <= 6) ? m[t-1] : 1'b0;
        bus_cycle(ack_addr(3'(t)), 2'b11, 3'(t), h, vexp(t), "R5 R6 R11 sweep");
      end
    end
    irq_req[6:1] = 6'h3F;
    tick();
    // R3
    for (int t = 0; t < 3; t++)
      bus_cycle(ack_addr(3'd4), 2'(t), 3'd4, 1'b0, 8'h00, "R3 type");
    // R4
    for (int b = 0; b < 32; b++) begin
      if (b >= 2 && b <= 4) continue;
      bus_cycle(ack_addr(3'd4) ^ (32'd1 << b), 2'b11, 3'd4, 1'b0, 8'h00, "R4 addr");
    end
    // R5 address level disagrees with modifier
    bus_cycle(ack_addr(3'd3), 2'b11, 3'd2, 1'b0, 8'h00, "R5 mismatch");
    // R7 no bus activity
    tick();
    check("R7 idle ta", ta, 0);
    check("R7 idle data", d_hi, 0);
    irq_req[6:1] = '0;
    tick();
    // R9 edge captured and held after line falls
    irq_req[7] = 1'b1; tick();
    irq_req[7] = 1'b0; tick();
    check("R9 ipl after rise", ipl, 7);
    for (int k = 0; k < 5; k++) tick();
    check("R9 ipl held", ipl, 7);
    // R8 acknowledge clears level 7
    bus_cycle(ack_addr(3'd7), 2'b11, 3'd7, 1'b1, vexp(7), "R8 ack7");
    check("R8 ipl after ack", ipl, 0);
    // R10 held line does not request again
    irq_req[7] = 1'b1; tick();
    check("R10 ipl rise", ipl, 7);
    bus_cycle(ack_addr(3'd7), 2'b11, 3'd7, 1'b1, vexp(7), "R10 ack held");
    tick();
    check("R10 held no rerequest", ipl, 0);
    irq_req[7] = 1'b0; tick();
    irq_req[7] = 1'b1; tick();
    check("R10 fresh edge", ipl, 7);
    irq_req[7] = 1'b0; tick();
    // R10 edge in the acknowledge clock survives the clear
    bus_valid = 1'b1; bus_addr = ack_addr(3'd7); bus_tt = 2'b11; bus_tm = 3'd7;
    tick();
    bus_valid = 1'b0;
    irq_req[7] = 1'b1;
    check("R10 collide ta", ta, 1);
    tick();
    check("R10 collide ipl", ipl, 7);
    irq_req[7] = 1'b0;
    tick();
    bus_cycle(ack_addr(3'd7), 2'b11, 3'd7, 1'b1, vexp(7), "R10 second ack");
    check("R10 ipl after second", ipl, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule